// File: doc/BRIEF.md
# Paired A/B Channel-Status Buffer Port

This block is the register-side front end of a two-subframe digital audio transmitter. It holds a user-visible buffer made of two parallel channel-status blocks, A and B, each 24 bytes deep. A host reaches the buffer through a byte-wide port. Each access opens with a start strobe that loads an address pointer, carries any number of byte reads or writes, and closes with an end strobe. After every completed address, the pointer steps forward on its own, so a whole block can move as one burst.

A mode input selects how a byte maps onto the A/B pair. In one-byte mode, one written byte lands in both the A and the B location of the addressed word. In two-byte mode, each address takes two bytes in turn, A first and B second. A second buffer on the transmit side receives the whole user buffer in a single cycle. This happens at a block boundary signalled by the transmitter, once a copy has been requested. The transmitter reads that buffer through an index port.

Top module: `chstat_pair_port`

## Requirements
- R1: After reset, rd_data is 0, tx_load is 0 and every transmit-buffer byte (tx_a, tx_b for every tx_idx 0..23) reads 0.
- R2: With two_byte=0, a write stores wr_data into both the A and the B byte at the pointer.
- R3: With two_byte=0, a read returns the A byte at the pointer, and the pointer advances after every byte read or written.
- R4: With two_byte=1, reads at one address return the A byte first and the B byte second. The pointer advances only after the B byte.
- R5: With two_byte=1, writes at one address take the A byte first and the B byte second. Both are stored when the B byte arrives, and the pointer then advances.
- R6: The pointer wraps from 23 to 0 during auto-increment. acc_start loads it from addr_in, and an addr_in above 23 loads 0.
- R7: If acc_end arrives after an A byte but before its B byte, the A byte is discarded. Stored data is unchanged, and the next access starts again with an A byte.
- R8: After a copy_req, the next cycle with blk_boundary high copies all 24 A and B bytes into the transmit buffer, and tx_load is high for exactly the following cycle. A copy_req in the same cycle as that boundary waits for a later boundary.
- R9: A copy_req that arrives after a write inside a still-open access is ignored. No copy and no tx_load follow at the next boundary.
- R10: rd_data changes only in the cycle after a read and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| two_byte | input | 1 | 0: one-byte access, 1: two-byte access |
| acc_start | input | 1 | Opens an access and loads the pointer |
| acc_end | input | 1 | Closes an access |
| addr_in | input | 5 | Start address for acc_start |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Byte read strobe |
| rd_data | output | 8 | Read byte, valid the cycle after rd_en |
| copy_req | input | 1 | Requests a user-to-transmit copy |
| blk_boundary | input | 1 | Transmit block boundary strobe |
| tx_load | output | 1 | Pulses the cycle after a copy |
| tx_idx | input | 5 | Transmit-buffer read index |
| tx_a | output | 8 | Transmit A byte at tx_idx |
| tx_b | output | 8 | Transmit B byte at tx_idx |

## Verification
The assertions assume that acc_start and acc_end never occur in the same cycle as a byte strobe. They also assume that reads and writes are not interleaved within one two-byte address, and that two_byte stays constant for the length of an access. The stimulus keeps to these rules: every strobe is a single-cycle pulse driven from a task that opens and closes accesses in cycles of their own. Bursts sweep the full 24-address block from offsets that force a wrap, in both modes.

// File: rtl/chstat_pair_port.sv
`timescale 1ns/1ps
module chstat_pair_port #(
  parameter int DEPTH = 24,
  parameter int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          two_byte,
  input  logic          acc_start,
  input  logic          acc_end,
  input  logic [AW-1:0] addr_in,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  input  logic          copy_req,
  input  logic          blk_boundary,
  output logic          tx_load,
  input  logic [AW-1:0] tx_idx,
  output logic [7:0]    tx_a,
  output logic [7:0]    tx_b
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [7:0] ua [DEPTH];
  logic [7:0] ub [DEPTH];
  logic [7:0] ta [DEPTH];
  logic [7:0] tb [DEPTH];
  logic [AW-1:0] ptr;
  logic [7:0] hold;
  logic phase, pending, wr_active;

  wire [AW-1:0] ptr_nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
  wire idx_ok = (tx_idx <= LAST);

  assign tx_a = idx_ok ? ta[tx_idx] : '0;
  assign tx_b = idx_ok ? tb[tx_idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      hold <= '0;
      phase <= 1'b0;
      pending <= 1'b0;
      wr_active <= 1'b0;
      rd_data <= '0;
      tx_load <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        ua[i] <= '0; ub[i] <= '0; ta[i] <= '0; tb[i] <= '0;
      end
    end else begin
      tx_load <= 1'b0;
      if (acc_start) begin
        ptr <= (addr_in <= LAST) ? addr_in : '0;
        phase <= 1'b0;
        wr_active <= 1'b0;
      end else if (acc_end) begin
        phase <= 1'b0;
        wr_active <= 1'b0;
      end else if (wr_en) begin
        wr_active <= 1'b1;
        if (!two_byte) begin
          ua[ptr] <= wr_data;
          ub[ptr] <= wr_data;
          ptr <= ptr_nxt;
        end else if (!phase) begin
          hold <= wr_data;
          phase <= 1'b1;
        end else begin
          ua[ptr] <= hold;
          ub[ptr] <= wr_data;
          ptr <= ptr_nxt;
          phase <= 1'b0;
        end
      end else if (rd_en) begin
        if (!two_byte) begin
          rd_data <= ua[ptr];
          ptr <= ptr_nxt;
        end else if (!phase) begin
          rd_data <= ua[ptr];
          phase <= 1'b1;
        end else begin
          rd_data <= ub[ptr];
          ptr <= ptr_nxt;
          phase <= 1'b0;
        end
      end

      if (blk_boundary && pending) begin
        for (int i = 0; i < DEPTH; i++) begin
          ta[i] <= ua[i];
          tb[i] <= ub[i];
        end
        pending <= 1'b0;
        tx_load <= 1'b1;
      end
      if (copy_req && !wr_active) pending <= 1'b1;
    end
  end
endmodule

// File: rtl/chstat_pair_port_chk.sv
`timescale 1ns/1ps
module chstat_pair_port_chk #(
  parameter int DEPTH = 24,
  parameter int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          two_byte,
  input logic          acc_start,
  input logic          acc_end,
  input logic          wr_en,
  input logic          rd_en,
  input logic [7:0]    rd_data,
  input logic          copy_req,
  input logic          blk_boundary,
  input logic          tx_load,
  input logic [AW-1:0] ptr,
  input logic          phase,
  input logic          pending,
  input logic          wr_active
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  wire quiet = !acc_start && !acc_end;

  a_r6_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);

  a_r3_one_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!two_byte && quiet && (wr_en || rd_en)) |=>
      ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));

  a_r5_a_byte_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (two_byte && quiet && wr_en && !phase) |=> (ptr == $past(ptr)) && phase);

  a_r4_b_read_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (two_byte && quiet && !wr_en && rd_en && phase) |=>
      !phase && ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));

  a_r7_end_clears_phase: assert property (@(posedge clk) disable iff (!rst_n)
    acc_end |=> !phase);

  a_r8_load_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> $past(blk_boundary && pending));

  a_r9_busy_copy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_req && wr_active && !pending) |=> !pending);

  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && quiet && !wr_en) |=> $stable(rd_data));
endmodule

bind chstat_pair_port chstat_pair_port_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .two_byte(two_byte), .acc_start(acc_start),
  .acc_end(acc_end), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
  .copy_req(copy_req), .blk_boundary(blk_boundary), .tx_load(tx_load),
  .ptr(ptr), .phase(phase), .pending(pending), .wr_active(wr_active)
);

// File: tb/chstat_pair_port_bench.sv
`timescale 1ns/1ps
module chstat_pair_port_bench;
  localparam int N = 24;
  logic clk = 0, rst_n = 0, two_byte = 0, acc_start = 0, acc_end = 0;
  logic wr_en = 0, rd_en = 0, copy_req = 0, blk_boundary = 0;
  logic [4:0] addr_in = 0, tx_idx = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data, tx_a, tx_b;
  logic tx_load;
  int checks = 0, failures = 0;
  int ma [N];
  int mb [N];
  int ta [N];
  int tb [N];
  bit done = 0;

  always #2.5 clk = ~clk;

  chstat_pair_port u_chstat_pair_port (
    .clk(clk), .rst_n(rst_n), .two_byte(two_byte), .acc_start(acc_start),
    .acc_end(acc_end), .addr_in(addr_in), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .copy_req(copy_req),
    .blk_boundary(blk_boundary), .tx_load(tx_load), .tx_idx(tx_idx),
    .tx_a(tx_a), .tx_b(tx_b)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  task automatic open_acc(int a);
    addr_in = 5'(a); pulse(acc_start);
  endtask

  task automatic close_acc();
    pulse(acc_end);
  endtask

  task automatic wr(int d);
    wr_data = 8'(d); pulse(wr_en);
  endtask

  task automatic rd(output int d);
    pulse(rd_en); d = rd_data;
  endtask

  task automatic check_tx(string req);
    for (int i = 0; i < N; i++) begin
      tx_idx = 5'(i); #0.1;
      check(req, tx_a, ta[i]);
      check(req, tx_b, tb[i]);
    end
  endtask

  initial begin
    #(5ns * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v, p;
    for (int i = 0; i < N; i++) begin ma[i] = 0; mb[i] = 0; ta[i] = 0; tb[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 rd_data", rd_data, 0);
    check("R1 tx_load", tx_load, 0);
    check_tx("R1 tx buffer");

    // one-byte burst starting at 5, wraps through 23 -> 0
    two_byte = 0;
    open_acc(5);
    for (int i = 0; i < N; i++) begin
      p = (5 + i) % N; v = (i * 37 + 11) & 255;
      wr(v); ma[p] = v; mb[p] = v;
    end
    close_acc();
    open_acc(5);
    for (int i = 0; i < N; i++) begin
      rd(v); check("R3/R6 one-byte read", v, ma[(5 + i) % N]);
    end
    close_acc();
    repeat (3) @(negedge clk);
    check("R10 rd_data holds", rd_data, ma[4]);

    // two-byte read of same data: A and B equal (R2), pointer steps after B (R4)
    two_byte = 1;
    open_acc(0);
    for (int i = 0; i <= N; i++) begin
      rd(v); check("R2/R4 A byte", v, ma[i % N]);
      rd(v); check("R2/R4 B byte", v, mb[i % N]);
    end
    close_acc();

    // two-byte burst from 20 with distinct A/B
    open_acc(20);
    for (int i = 0; i < N; i++) begin
      p = (20 + i) % N;
      ma[p] = (i * 5 + 1) & 255; mb[p] = (255 - i * 3) & 255;
      wr(ma[p]); wr(mb[p]);
    end
    close_acc();
    open_acc(20);
    for (int i = 0; i < N; i++) begin
      p = (20 + i) % N;
      rd(v); check("R5 A byte", v, ma[p]);
      rd(v); check("R5 B byte", v, mb[p]);
    end
    close_acc();
    two_byte = 0;
    open_acc(30);
    rd(v); check("R6 out-of-range start reads loc 0", v, ma[0]);
    rd(v); check("R3 one-byte read returns A", v, ma[1]);
    close_acc();

    // half-finished two-byte write discarded
    two_byte = 1;
    open_acc(3); wr(8'hAA); close_acc();
    open_acc(3);
    rd(v); check("R7 A unchanged", v, ma[3]);
    rd(v); check("R7 B unchanged", v, mb[3]);
    close_acc();
    open_acc(3); wr(8'h11); wr(8'h22); close_acc();
    ma[3] = 8'h11; mb[3] = 8'h22;
    open_acc(3);
    rd(v); check("R7 restart A", v, 8'h11);
    rd(v); check("R7 restart B", v, 8'h22);
    close_acc();

    // copy at boundary
    pulse(copy_req);
    @(negedge clk);
    check("R8 no load before boundary", tx_load, 0);
    check_tx("R8 tx unchanged before boundary");
    pulse(blk_boundary);
    check("R8 tx_load pulse", tx_load, 1);
    for (int i = 0; i < N; i++) begin ta[i] = ma[i]; tb[i] = mb[i]; end
    check_tx("R8 tx contents");
    @(negedge clk);
    check("R8 tx_load single cycle", tx_load, 0);
    pulse(blk_boundary);
    check("R8 no second load", tx_load, 0);

    // copy request during open write access ignored
    two_byte = 0;
    open_acc(0); wr(8'h5A); ma[0] = 8'h5A; mb[0] = 8'h5A;
    pulse(copy_req);
    close_acc();
    pulse(blk_boundary);
    check("R9 no load when busy", tx_load, 0);
    check_tx("R9 tx unchanged");
    pulse(copy_req);
    pulse(blk_boundary);
    check("R9 later request loads", tx_load, 1);
    ta[0] = 8'h5A; tb[0] = 8'h5A;
    check_tx("R9 tx after load");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule